// File: doc/BRIEF.md
# Link Bus Request Serializer

This block lives on the link side of a PHY-link interface. It turns one bus or register request from the link controller into a short serial frame on a single request line, one bit per system clock. The controller offers a 3-bit request type, a 4-bit field and, for register writes, an 8-bit data byte. The field is a register address for reads and writes, and a speed/tag value for bus requests. The serializer accepts the request when `req_ready` is high and holds it until the frame has gone out.

The block samples the two control pins on every clock. The pins are 00 idle, 01 status, 10 receive and 11 transmit. A fair or priority request is held back until the interface has been idle for a full clock. If the PHY starts a receive while such a request is on the line, or while it waits for the grant, the request counts as lost. The serializer then raises a one-cycle lost flag, drops the line, and sends the same frame again once the interface is idle again. An immediate request, used to send an acknowledgment, goes out only while a packet is still arriving. Isochronous and register requests go out at once.

Top module: `link_req_serializer`

## Requirements
- R1: A frame is a start bit 1, then the 3 type bits most significant first, then the 4 field bits most significant first, then a stop bit 0. Non-write frames are 9 bits long. `req_line` carries frame bit k in the k-th cycle after the start edge, with bit 0 in the cycle right after that edge, and is low at all other times.
- R2: A register write (type 101) adds its 8 data bits, most significant first, between the field and the stop bit, for a 17-bit frame.
- R3: A fair (011) or priority (010) request starts only at a clock edge where `ctl` is sampled as 00 both at that edge and at the edge before it.
- R4: If `ctl` reads 10 while a fair or priority frame is being sent, or while the block waits for its grant, `req_lost` pulses for one cycle and `req_line` is low from that edge on.
- R5: After a loss, the whole frame is sent again under the R3 rule. It is not reissued while `ctl` is not idle.
- R6: `req_done` pulses for one cycle. For non-arbitrated types it comes at the edge after the stop bit. For fair and priority requests it comes at the first edge after the frame where `ctl` reads 11 (transmit). It is never high together with `req_lost`.
- R7: An immediate request (000) starts only at an edge where `ctl` reads 10, and receive is never a loss for it.
- R8: Isochronous (001), register read (100) and register write (101) requests start at the first edge after acceptance, whatever `ctl` shows.
- R9: The reserved codes 110 and 111 are accepted and dropped. No frame is sent, no done is raised, and `req_ready` stays high.
- R10: After reset, `req_line` is low. `req_ready` stays low until an edge has sampled `ctl` as 00.
- R11: `req_ready` is high only while no request is held. A request is taken at an edge where both `req_valid` and `req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered by the link controller |
| req_type | input | 3 | Request type code |
| req_field | input | 4 | Register address or speed/tag field |
| req_data | input | 8 | Write data (register write only) |
| ctl | input | 2 | Control pins: 00 idle, 01 status, 10 receive, 11 transmit |
| req_ready | output | 1 | Block can accept a request |
| req_line | output | 1 | Serial request line |
| req_done | output | 1 | One-cycle pulse when the request has completed |
| req_lost | output | 1 | One-cycle pulse when a fair/priority request was lost |

## Verification
The bench targets the start conditions, because a design that gets them wrong starts on the wrong edge. A fair request released from transmit must wait for a second idle sample. A gate that looks at one sample would start a cycle early. An immediate request must sit quiet until receive shows up, while a read must start even during transmit. Loss is provoked in the middle of a frame and again while the block waits for the grant. A design that ignores receive, keeps the line high after a loss, or retries before idle would either drop the frame or send an extra one. The scoreboard also catches reserved codes that leak onto the line, and a done that arrives before the grant for an arbitrated request.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    parameter int unsigned KIND_W = 3;
    parameter int unsigned ADDR_W = 4;
    parameter int unsigned DATA_W = 8;

    localparam int unsigned HEAD_W    = 1 + KIND_W + ADDR_W;
    localparam int unsigned FRAME_MAX = HEAD_W + DATA_W + 1;
    localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [KIND_W-1:0] {
        RQ_IMM  = 3'd0,
        RQ_ISO  = 3'd1,
        RQ_PRI  = 3'd2,
        RQ_FAIR = 3'd3,
        RQ_RD   = 3'd4,
        RQ_WR   = 3'd5,
        RQ_RSV6 = 3'd6,
        RQ_RSV7 = 3'd7
    } rq_kind_e;

    typedef enum logic [1:0] {
        CTL_IDLE   = 2'b00,
        CTL_STATUS = 2'b01,
        CTL_RX     = 2'b10,
        CTL_TX     = 2'b11
    } ctl_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARM,
        S_SEND,
        S_WAIT
    } lrs_state_e;

    typedef struct packed {
        rq_kind_e          kind;
        logic [ADDR_W-1:0] field;
        logic [DATA_W-1:0] data;
    } rq_t;

    function automatic logic is_arb(rq_kind_e k);
        return (k == RQ_PRI) || (k == RQ_FAIR);
    endfunction

    function automatic logic is_reserved(rq_kind_e k);
        return (k == RQ_RSV6) || (k == RQ_RSV7);
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(rq_kind_e k);
        if (k == RQ_WR) return CNT_W'(FRAME_MAX);
        return CNT_W'(HEAD_W + 1);
    endfunction

    function automatic logic [FRAME_MAX-1:0] build_frame(rq_t r);
        logic [FRAME_MAX-1:0] f;
        f    = '0;
        f[0] = 1'b1;
        for (int i = 0; i < KIND_W; i++) f[1 + i] = r.kind[KIND_W - 1 - i];
        for (int i = 0; i < ADDR_W; i++) f[1 + KIND_W + i] = r.field[ADDR_W - 1 - i];
        if (r.kind == RQ_WR)
            for (int i = 0; i < DATA_W; i++) f[HEAD_W + i] = r.data[DATA_W - 1 - i];
        return f;
    endfunction

endpackage

// File: rtl/lrs_start_gate.sv
module lrs_start_gate
    import lrs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctl_e     ctl,
    input  rq_kind_e kind,
    output logic     boot_ok,
    output logic     may_start,
    output logic     rx_now
);
    logic idle_q;
    logic boot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b0;
            boot_q <= 1'b0;
        end else begin
            idle_q <= (ctl == CTL_IDLE);
            boot_q <= boot_q | (ctl == CTL_IDLE);
        end
    end

    assign boot_ok = boot_q;
    assign rx_now  = (ctl == CTL_RX);

    always_comb begin
        if (!boot_q)
            may_start = 1'b0;
        else if (is_arb(kind))
            may_start = idle_q && (ctl == CTL_IDLE);
        else if (kind == RQ_IMM)
            may_start = (ctl == CTL_RX);
        else
            may_start = 1'b1;
    end
endmodule

// File: rtl/lrs_shifter.sv
module lrs_shifter
    import lrs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 advance,
    input  logic                 clear,
    input  logic [FRAME_MAX-1:0] frame,
    input  logic [CNT_W-1:0]     len,
    output logic                 line,
    output logic                 last
);
    logic [FRAME_MAX-1:0] shift_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
            line_q  <= 1'b0;
        end else if (load) begin
            line_q  <= frame[0];
            shift_q <= frame >> 1;
            cnt_q   <= len - CNT_W'(1);
        end else if (clear) begin
            line_q  <= 1'b0;
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (advance) begin
            line_q  <= shift_q[0];
            shift_q <= shift_q >> 1;
            cnt_q   <= cnt_q - CNT_W'(1);
        end
    end

    assign line = line_q;
    assign last = (cnt_q == '0);
endmodule

// File: rtl/link_req_serializer.sv
module link_req_serializer
    import lrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_type,
    input  logic [ADDR_W-1:0] req_field,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        ctl,
    output logic              req_ready,
    output logic              req_line,
    output logic              req_done,
    output logic              req_lost
);
    lrs_state_e state_q;
    rq_t        held_q;
    logic       done_q, lost_q;
    logic       boot_ok, may_start, rx_now, last;
    logic       load, advance, clear, lose;
    ctl_e       ctl_v;
    rq_kind_e   in_kind;
    logic [KIND_W-1:0] held_kind;
    logic       sending;

    assign ctl_v     = ctl_e'(ctl);
    assign in_kind   = rq_kind_e'(req_type);
    assign held_kind = held_q.kind;
    assign sending   = (state_q == S_SEND);

    lrs_start_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_v),
        .kind      (held_q.kind),
        .boot_ok   (boot_ok),
        .may_start (may_start),
        .rx_now    (rx_now)
    );

    assign req_ready = (state_q == S_IDLE) && boot_ok;
    assign load      = (state_q == S_ARM) && may_start;
    assign lose      = is_arb(held_q.kind) && rx_now &&
                       ((state_q == S_SEND) || (state_q == S_WAIT));
    assign clear     = sending && (lose || last);
    assign advance   = sending && !clear;

    lrs_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (advance),
        .clear   (clear),
        .frame   (build_frame(held_q)),
        .len     (frame_len(held_q.kind)),
        .line    (req_line),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            held_q  <= '0;
            done_q  <= 1'b0;
            lost_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            lost_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid && req_ready && !is_reserved(in_kind)) begin
                        held_q  <= '{kind: in_kind, field: req_field, data: req_data};
                        state_q <= S_ARM;
                    end
                end
                S_ARM: begin
                    if (may_start) state_q <= S_SEND;
                end
                S_SEND: begin
                    if (lose) begin
                        lost_q  <= 1'b1;
                        state_q <= S_ARM;
                    end else if (last) begin
                        if (is_arb(held_q.kind)) begin
                            state_q <= S_WAIT;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    end
                end
                S_WAIT: begin
                    if (lose) begin
                        lost_q  <= 1'b1;
                        state_q <= S_ARM;
                    end else if (ctl_v == CTL_TX) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign req_done = done_q;
    assign req_lost = lost_q;
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ctl,
    input logic       line,
    input logic       ready,
    input logic       done,
    input logic       lost,
    input logic       sending,
    input logic [2:0] kind
);
    logic arb;
    assign arb = (kind == 3'b010) || (kind == 3'b011);

    assert_arb_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (sending && !$past(sending) && arb) |->
            ($past(ctl) == 2'b00 && $past(ctl, 2) == 2'b00));

    assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
        (sending && !$past(sending)) |-> line);

    assert_imm_in_rx_R7: assert property (@(posedge clk) disable iff (rst)
        (sending && !$past(sending) && kind == 3'b000) |-> ($past(ctl) == 2'b10));

    assert_done_lost_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(done && lost));

    assert_lost_arb_R4: assert property (@(posedge clk) disable iff (rst)
        lost |-> (arb && !line));

    assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!line && !sending));
endmodule

bind link_req_serializer lrs_checker u_lrs_checker (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .line    (req_line),
    .ready   (req_ready),
    .done    (req_done),
    .lost    (req_lost),
    .sending (sending),
    .kind    (held_kind)
);

// File: tb/test_link_req_serializer.sv
module test_link_req_serializer;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [2:0] req_type;
    logic [3:0] req_field;
    logic [7:0] req_data;
    logic [1:0] ctl;
    logic       req_ready, req_line, req_done, req_lost;

    always #5 clk = ~clk;

    link_req_serializer i_link_req_serializer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
        .req_field(req_field), .req_data(req_data), .ctl(ctl),
        .req_ready(req_ready), .req_line(req_line),
        .req_done(req_done), .req_lost(req_lost)
    );

    typedef struct {
        logic [16:0] bits;
        int          len;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   strict = 1'b1;
    bit   finished = 1'b0;
    int   cyc = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // frame per R1/R2: start 1, type MSB first, field MSB first, data MSB first (write), stop 0
    function automatic exp_t make_exp(logic [2:0] t, logic [3:0] f, logic [7:0] d);
        exp_t e;
        int   p;
        e.bits = '0;
        e.bits[0] = 1'b1;
        p = 1;
        for (int i = 2; i >= 0; i--) begin e.bits[p] = t[i]; p++; end
        for (int i = 3; i >= 0; i--) begin e.bits[p] = f[i]; p++; end
        if (t == 3'b101)
            for (int i = 7; i >= 0; i--) begin e.bits[p] = d[i]; p++; end
        e.len = p + 1;
        return e;
    endfunction

    // monitor: pops an expected frame at each frame start and compares it bit by bit
    bit          cap_on = 1'b0;
    exp_t        cur;
    int          cap_i;
    logic [16:0] cap;
    always @(negedge clk) begin
        if (!rst) begin
            if (!cap_on && req_line) begin
                if (exp_q.size() > 0) begin
                    cur    = exp_q.pop_front();
                    cap_on = 1'b1;
                    cap_i  = 0;
                    cap    = '0;
                end else if (strict) begin
                    chk(1'b0, "R9 unexpected frame start", 32'(req_line), 32'd0);
                end
            end
            if (cap_on) begin
                cap[cap_i] = req_line;
                cap_i++;
                if (cap_i == cur.len) begin
                    cap_on = 1'b0;
                    chk(cap == cur.bits, (cur.len == 17) ? "R2 write frame" : "R1 frame",
                        32'(cap), 32'(cur.bits));
                end
            end
        end
    end

    task automatic issue(input logic [2:0] t, input logic [3:0] f, input logic [7:0] d, input bit push);
        @(negedge clk);
        chk(req_ready, "R11 ready before issue", 32'(req_ready), 32'd1);
        if (push) exp_q.push_back(make_exp(t, f, d));
        req_valid = 1'b1; req_type = t; req_field = f; req_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // counts negedges until req_done is high
    task automatic wait_done(output int k);
        k = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (req_done) begin k = i; break; end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        bit ok;
        rst = 1'b1; req_valid = 1'b0; req_type = '0; req_field = '0; req_data = '0;
        ctl = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: no idle seen yet, so not ready and line low even with a request offered
        req_valid = 1'b1; req_type = 3'b100; req_field = 4'h1;
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (req_ready || req_line) ok = 1'b0;
        end
        chk(ok, "R10 quiet before first idle", 32'({req_ready, req_line}), 32'd0);
        req_valid = 1'b0;
        ctl = 2'b00;
        @(negedge clk);
        chk(req_ready, "R10 ready after idle", 32'(req_ready), 32'd1);

        // R8 read during transmit starts at once; R6 done after stop bit
        ctl = 2'b11;
        issue(3'b100, 4'hA, 8'h00, 1'b1);
        chk(!req_line, "R8 read not yet started", 32'(req_line), 32'd0);
        @(negedge clk);
        chk(req_line, "R8 read start bit", 32'(req_line), 32'd1);
        chk(!req_ready, "R11 not ready while busy", 32'(req_ready), 32'd0);
        wait_done(k);
        chk(k == 9, "R6 read done timing", 32'(k), 32'd9);

        // R2 write frame, 17 bits
        ctl = 2'b00;
        issue(3'b101, 4'h3, 8'hC6, 1'b1);
        @(negedge clk);
        chk(req_line, "R8 write start bit", 32'(req_line), 32'd1);
        wait_done(k);
        chk(k == 17, "R2 write done timing", 32'(k), 32'd17);

        // R8/R4 isochronous during receive: starts, never lost
        ctl = 2'b10;
        issue(3'b001, 4'h6, 8'h00, 1'b1);
        @(negedge clk);
        chk(req_line, "R8 iso start in receive", 32'(req_line), 32'd1);
        ok = 1'b1;
        k  = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (req_lost) ok = 1'b0;
            if (req_done) begin k = i; break; end
        end
        chk(ok, "R4 iso not lost", 32'(ok), 32'd1);
        chk(k == 9, "R6 iso done timing", 32'(k), 32'd9);

        // R9 reserved codes dropped
        ctl = 2'b00;
        for (int c = 6; c <= 7; c++) begin
            issue(3'(c), 4'hF, 8'hFF, 1'b0);
            ok = 1'b1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (req_line || req_done || !req_ready) ok = 1'b0;
            end
            chk(ok, "R9 reserved code ignored", 32'({req_line, req_done, req_ready}), 32'd1);
        end

        // R7 immediate waits for receive
        ctl = 2'b00;
        issue(3'b000, 4'h9, 8'h00, 1'b1);
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (req_line) ok = 1'b0;
        end
        chk(ok, "R7 immediate held outside receive", 32'(req_line), 32'd0);
        ctl = 2'b10;
        @(negedge clk);
        chk(req_line, "R7 immediate start in receive", 32'(req_line), 32'd1);
        wait_done(k);
        chk(k == 9, "R7 immediate completes in receive", 32'(k), 32'd9);

        // R3 fair request needs two idle samples
        ctl = 2'b11;
        issue(3'b011, 4'h2, 8'h00, 1'b1);
        repeat (3) @(negedge clk);
        chk(!req_line, "R3 fair held during transmit", 32'(req_line), 32'd0);
        ctl = 2'b00;
        @(negedge clk);
        chk(!req_line, "R3 fair not after one idle", 32'(req_line), 32'd0);
        @(negedge clk);
        chk(req_line, "R3 fair start after idle", 32'(req_line), 32'd1);
        ok = 1'b1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (req_done) ok = 1'b0;
        end
        chk(ok, "R6 fair waits for grant", 32'(req_done), 32'd0);
        ctl = 2'b11;
        @(negedge clk);
        chk(req_done, "R6 fair done on transmit", 32'(req_done), 32'd1);

        // R4/R5 priority lost mid-frame, then after frame
        ctl = 2'b00;
        strict = 1'b0;
        issue(3'b010, 4'h5, 8'h00, 1'b0);
        @(negedge clk);
        chk(req_line, "R3 priority start", 32'(req_line), 32'd1);
        @(negedge clk);
        ctl = 2'b10;
        @(negedge clk);
        chk(req_lost, "R4 lost during frame", 32'(req_lost), 32'd1);
        chk(!req_line, "R4 line dropped on loss", 32'(req_line), 32'd0);
        ok = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (req_line) ok = 1'b0;
        end
        chk(ok, "R5 no reissue during receive", 32'(req_line), 32'd0);
        exp_q.push_back(make_exp(3'b010, 4'h5, 8'h00));
        strict = 1'b1;
        ctl = 2'b00;
        @(negedge clk);
        chk(!req_line, "R5 reissue waits one idle", 32'(req_line), 32'd0);
        @(negedge clk);
        chk(req_line, "R5 reissue start", 32'(req_line), 32'd1);
        repeat (12) @(negedge clk);
        ctl = 2'b10;
        @(negedge clk);
        chk(req_lost, "R4 lost while waiting", 32'(req_lost), 32'd1);
        exp_q.push_back(make_exp(3'b010, 4'h5, 8'h00));
        ctl = 2'b00;
        @(negedge clk);
        @(negedge clk);
        chk(req_line, "R5 second reissue start", 32'(req_line), 32'd1);
        repeat (12) @(negedge clk);
        ctl = 2'b11;
        @(negedge clk);
        chk(req_done && !req_lost, "R6 priority done", 32'({req_done, req_lost}), 32'd2);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0 && !cap_on, "R1 all frames seen", 32'(exp_q.size()), 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule